// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one byte at a time into an asynchronous serial frame on a single output line. A byte written through a strobe lands in a one-entry holding register. From there it moves into a shift stage as soon as that stage is idle, and it goes out as a start bit, five to eight data bits, an optional parity bit and a stop period of one, one and a half or two bit times. A seven-bit line-control input sets the frame shape. The line can also be forced low on request to signal a break condition.

Timing comes from an external baud tick, which is high for one clock cycle per tick. Every bit on the line lasts a fixed number of ticks, 16 by default. The format fields of the line-control input are captured when a frame starts, so software may rewrite them while a frame is on the wire. The break request is not captured this way and acts on the line at once. Two flags guide the writer: `hold_full` shows that the holding register is occupied, and `tx_empty` shows that nothing is waiting and nothing is being shifted.

Top module: `uart_tx_framer`

## Requirements
- R1: During and right after reset, `txd` is 1, `tx_empty` is 1 and `hold_full` is 0.
- R2: The line rests at 1. Each frame opens with one start bit at 0, and every bit lasts 16 consumed baud ticks.
- R3: `line_ctrl[1:0]` sets the data bits per frame: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The data bits leave least significant first, and higher bits of the byte are not sent.
- R4: With `line_ctrl[2]` = 0 the stop period is 16 ticks. With `line_ctrl[2]` = 1 it is 24 ticks for a 5-bit word and 32 ticks for longer words. `tx_empty` returns to 1 exactly when the stop period ends, provided nothing is queued.
- R5: With `line_ctrl[3]` = 1, one parity bit follows the last data bit and comes before the stop period. With `line_ctrl[3]` = 0 no parity bit is sent.
- R6: With parity on and `line_ctrl[5]` = 0, `line_ctrl[4]` = 0 makes the count of ones in the data bits plus the parity bit odd. `line_ctrl[4]` = 1 makes that count even.
- R7: With parity on and `line_ctrl[5]` = 1, the parity bit is a constant: 1 when `line_ctrl[4]` = 0 and 0 when `line_ctrl[4]` = 1.
- R8: While `line_ctrl[6]` is 1, `txd` is 0 from the next clock on, whether a frame is running or the line is idle. Frame timing still advances, and `tx_empty` rises at the same tick it would without the break.
- R9: `line_ctrl[5:0]` is sampled when a frame starts. Changes made later do not affect that frame.
- R10: A write sets `hold_full` when the holding register is free. A write while `hold_full` is 1 is discarded. `tx_empty` is 1 only when the holding register is free and no frame is running.
- R11: A byte written while a frame is running waits in the holding register. It starts on its own once the current stop period ends, with no baud tick needed to start it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle tick; 16 ticks make one bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| line_ctrl | input | 7 | Frame format [5:0] and break request [6] |
| txd | output | 1 | Serial line output |
| tx_empty | output | 1 | Holding register free and shift stage idle |
| hold_full | output | 1 | Holding register occupied |

## Verification
The hardest case to reach is a write that arrives while the holding register is still occupied behind a running frame. The bench writes a byte and waits until the shift stage has taken it. It then queues a second byte and fires a third write straight away. A third frame never appears and `tx_empty` rises after the second frame, which shows at the line that the third byte was discarded. Two more cases are hard to see from outside: the format being rewritten just after a frame has started, and a break held for the whole of a frame. In both, the bench keeps counting ticks and checks that the end of the frame falls on the same tick as the frame's original format predicts.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int unsigned WORD_MAX = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_e;

    // Frame shape fields captured at frame start
    typedef struct packed {
        logic [1:0] wlen;       // 0..3 -> 5..8 data bits
        logic       long_stop;  // 1.5 or 2 stop bits
        logic       par_on;     // parity bit present
    } shape_t;

    typedef struct packed {
        logic even;
        logic stick;
    } par_mode_t;

    function automatic shape_t get_shape(input logic [3:0] ctrl);
        shape_t s;
        s.wlen      = ctrl[1:0];
        s.long_stop = ctrl[2];
        s.par_on    = ctrl[3];
        return s;
    endfunction

    function automatic par_mode_t get_par_mode(input logic [1:0] ctrl);
        par_mode_t m;
        m.even  = ctrl[0];
        m.stick = ctrl[1];
        return m;
    endfunction

    // Index of the final data bit for a word-length code
    function automatic logic [2:0] last_index(input logic [1:0] wlen);
        return 3'd4 + {1'b0, wlen};
    endfunction

endpackage

// File: rtl/utx_hold_reg.sv
module utx_hold_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             take,
    output logic             full,
    output logic [WIDTH-1:0] data
);

    typedef struct packed {
        logic             full;
        logic [WIDTH-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end
        // a write into an occupied register is dropped
        if (wr_en && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign data = st_q.data;

endmodule

// File: rtl/utx_parity_gen.sv
module utx_parity_gen
    import utx_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_MAX
) (
    input  logic [WIDTH-1:0] data,
    input  logic [1:0]       wlen,
    input  par_mode_t        mode,
    output logic             par_bit
);

    logic [WIDTH-1:0] masked;
    logic             ones_odd;

    for (genvar g = 0; g < WIDTH; g++) begin : g_mask
        assign masked[g] = data[g] & (3'(g) <= last_index(wlen));
    end

    assign ones_odd = ^masked;

    always_comb begin
        if (mode.stick) begin
            par_bit = ~mode.even;
        end else if (mode.even) begin
            par_bit = ones_odd;
        end else begin
            par_bit = ~ones_odd;
        end
    end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned WIDTH         = WORD_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             ld_valid,
    input  logic [WIDTH-1:0] ld_data,
    input  shape_t           ld_shape,
    input  logic             ld_par,
    output logic             ld_take,
    output logic             busy,
    output logic             line_bit
);

    localparam int unsigned  CNT_W        = $clog2(2 * TICKS_PER_BIT);
    localparam logic [CNT_W:0] LEN_BIT      = (CNT_W + 1)'(TICKS_PER_BIT);
    localparam logic [CNT_W:0] LEN_ONE_HALF = (CNT_W + 1)'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    localparam logic [CNT_W:0] LEN_TWO      = (CNT_W + 1)'(2 * TICKS_PER_BIT);
    localparam logic [CNT_W:0] LEN_UNIT     = (CNT_W + 1)'(1);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       idx;
        logic [WIDTH-1:0] shreg;
        shape_t           shape;
        logic             par;
    } sh_t;

    sh_t            st_d, st_q;
    logic [CNT_W:0] phase_len;
    logic           at_end;

    always_comb begin
        phase_len = LEN_BIT;
        if (st_q.phase == PH_STOP && st_q.shape.long_stop) begin
            phase_len = (st_q.shape.wlen == 2'b00) ? LEN_ONE_HALF : LEN_TWO;
        end
        at_end = ({1'b0, st_q.cnt} == (phase_len - LEN_UNIT));
    end

    always_comb begin
        st_d    = st_q;
        ld_take = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (ld_valid) begin
                ld_take     = 1'b1;
                st_d.phase  = PH_START;
                st_d.cnt    = '0;
                st_d.idx    = '0;
                st_d.shreg  = ld_data;
                st_d.shape  = ld_shape;
                st_d.par    = ld_par;
            end
        end else if (baud_tick) begin
            if (!at_end) begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end else begin
                st_d.cnt = '0;
                case (st_q.phase)
                    PH_START: st_d.phase = PH_DATA;
                    PH_DATA: begin
                        st_d.shreg = st_q.shreg >> 1;
                        if (st_q.idx == last_index(st_q.shape.wlen)) begin
                            st_d.phase = st_q.shape.par_on ? PH_PARITY : PH_STOP;
                        end else begin
                            st_d.idx = st_q.idx + 3'd1;
                        end
                    end
                    PH_PARITY: st_d.phase = PH_STOP;
                    default:   st_d.phase = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.phase)
            PH_START:  line_bit = 1'b0;
            PH_DATA:   line_bit = st_q.shreg[0];
            PH_PARITY: line_bit = st_q.par;
            default:   line_bit = 1'b1;
        endcase
    end

    assign busy = (st_q.phase != PH_IDLE);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import utx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [6:0] line_ctrl,
    output logic       txd,
    output logic       tx_empty,
    output logic       hold_full
);

    typedef struct packed {
        logic brk;
    } top_t;

    top_t      top_d, top_q;
    logic      brk_q;
    logic [7:0] hold_data;
    logic      take;
    logic      sh_busy;
    logic      sh_line;
    logic      par_bit;
    shape_t    cur_shape;
    par_mode_t cur_mode;

    assign cur_shape = get_shape(line_ctrl[3:0]);
    assign cur_mode  = get_par_mode(line_ctrl[5:4]);

    utx_hold_reg #(.WIDTH(WORD_MAX)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    utx_parity_gen #(.WIDTH(WORD_MAX)) u_par (
        .data    (hold_data),
        .wlen    (cur_shape.wlen),
        .mode    (cur_mode),
        .par_bit (par_bit)
    );

    utx_shifter #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .WIDTH         (WORD_MAX)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .ld_valid  (hold_full),
        .ld_data   (hold_data),
        .ld_shape  (cur_shape),
        .ld_par    (par_bit),
        .ld_take   (take),
        .busy      (sh_busy),
        .line_bit  (sh_line)
    );

    always_comb begin
        top_d     = top_q;
        top_d.brk = line_ctrl[6];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign brk_q    = top_q.brk;
    assign txd      = brk_q ? 1'b0 : sh_line;
    assign tx_empty = !hold_full && !sh_busy;

endmodule

// File: rtl/utx_framer_chk.sv
module utx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic brk_req,
    input logic txd,
    input logic tx_empty,
    input logic hold_full,
    input logic brk_q,
    input logic sh_busy,
    input logic sh_line
);

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !txd); // R8

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !brk_q) |-> txd); // R2

    AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_busy) |-> !sh_line); // R2

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hold_full) |=> hold_full); // R10

    AST_QUEUE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && sh_busy) |=> hold_full); // R11

    AST_HANDOFF_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_full) |-> sh_busy); // R11

endmodule

bind uart_tx_framer utx_framer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .brk_req   (line_ctrl[6]),
    .txd       (txd),
    .tx_empty  (tx_empty),
    .hold_full (hold_full),
    .brk_q     (brk_q),
    .sh_busy   (sh_busy),
    .sh_line   (sh_line)
);

// File: tb/uart_tx_framer_tb.sv
module uart_tx_framer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] line_ctrl = '0;
    logic       txd;
    logic       tx_empty;
    logic       hold_full;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_tx_framer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .line_ctrl (line_ctrl),
        .txd       (txd),
        .tx_empty  (tx_empty),
        .hold_full (hold_full)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_nbits(input logic [6:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [6:0] c);
        logic ones = 1'b0;
        for (int i = 0; i < exp_nbits(c); i++) ones ^= d[i];
        if (c[5]) return ~c[4];
        return c[4] ? ones : ~ones;
    endfunction

    function automatic int exp_stop(input logic [6:0] c);
        if (!c[2]) return 16;
        return (c[1:0] == 2'b00) ? 24 : 32;
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input logic [6:0] c, input int k);
        if (k == 0) return 1'b0;
        if (k <= exp_nbits(c)) return d[k-1];
        if (c[3] && k == exp_nbits(c) + 1) return exp_par(d, c);
        return 1'b1;
    endfunction

    task automatic do_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_start();
        int guard = 0;
        while (!(!hold_full && !tx_empty) && guard < 10) begin
            @(negedge clk);
            guard++;
        end
        check("R11 frame start", 32'(guard < 10), 32'd1);
    endtask

    // Drives ticks through one frame whose format is c and checks the line
    task automatic run_ticks(input logic [7:0] d, input logic [6:0] c,
                             input bit check_end, input bit brk, input string tag_over);
        int nb    = 1 + exp_nbits(c) + (c[3] ? 1 : 0);
        int stop  = exp_stop(c);
        int tot   = 16 * nb + stop;
        string tg;
        for (int t = 1; t <= tot; t++) begin
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            if (t % 16 == 8 && t < 16 * nb) begin
                int k = t / 16;
                if (k == 0)                tg = "R2 start";
                else if (k <= exp_nbits(c)) tg = "R3 data";
                else if (c[5])             tg = "R7 stick parity";
                else                       tg = "R5 R6 parity";
                if (brk) tg = "R8 break";
                if (tag_over != "") tg = tag_over;
                check(tg, 32'(txd), 32'(brk ? 1'b0 : exp_bit(d, c, k)));
            end
            if (t == 16 * nb + 8 || (stop == 32 && t == 16 * nb + 24))
                check(brk ? "R8 stop" : "R4 stop level", 32'(txd), 32'(!brk));
            if (t == tot - 1)
                check("R4 frame still running", 32'(tx_empty), 32'd0);
            if (t == tot && check_end) begin
                check("R4 frame length", 32'(tx_empty), 32'd1);
                check(brk ? "R8 line" : "R2 idle high", 32'(txd), 32'(!brk));
            end
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic [6:0] c);
        line_ctrl = c;
        do_write(d);
        wait_start();
        run_ticks(d, c, 1'b1, c[6], "");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check("R1 txd in reset", 32'(txd), 32'd1);
        check("R1 empty in reset", 32'(tx_empty), 32'd1);
        check("R1 hold in reset", 32'(hold_full), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 txd after reset", 32'(txd), 32'd1);
        check("R1 empty after reset", 32'(tx_empty), 32'd1);

        // R3 each word length, one stop, no parity
        send(8'hB5, 7'h00);
        send(8'h6A, 7'h01);
        send(8'hD3, 7'h02);
        send(8'h81, 7'h03);
        // R4 long stop: 1.5 for 5-bit, 2 otherwise
        send(8'h15, 7'h04);
        send(8'hC7, 7'h07);
        send(8'h2E, 7'h05);
        // R5 R6 R7 parity modes
        send(8'h37, 7'h0B);
        send(8'h37, 7'h1B);
        send(8'h00, 7'h0B);
        send(8'hF0, 7'h2B);
        send(8'hF0, 7'h3B);
        send(8'h0F, 7'h38);

        // R9 format rewritten right after the frame started
        line_ctrl = 7'h0B;
        do_write(8'h9C);
        wait_start();
        line_ctrl = 7'h34;
        run_ticks(8'h9C, 7'h0B, 1'b1, 1'b0, "R9 latched format");

        // R8 break over a whole frame, then on an idle line
        send(8'h55, 7'h43);
        line_ctrl = 7'h00;
        repeat (2) @(negedge clk);
        check("R8 break released", 32'(txd), 32'd1);
        line_ctrl = 7'h40;
        repeat (2) @(negedge clk);
        check("R8 idle break", 32'(txd), 32'd0);
        check("R8 idle break empty", 32'(tx_empty), 32'd1);
        line_ctrl = 7'h00;
        repeat (2) @(negedge clk);
        check("R8 idle release", 32'(txd), 32'd1);

        // R10 R11 queued byte and dropped third write
        line_ctrl = 7'h03;
        do_write(8'hA5);
        wait_start();
        do_write(8'h3C);
        check("R10 queued full", 32'(hold_full), 32'd1);
        check("R10 not empty", 32'(tx_empty), 32'd0);
        do_write(8'hFF);
        check("R10 still full", 32'(hold_full), 32'd1);
        run_ticks(8'hA5, 7'h03, 1'b0, 1'b0, "");
        wait_start();
        run_ticks(8'h3C, 7'h03, 1'b1, 1'b0, "R11 queued frame");
        repeat (5) @(negedge clk);
        check("R10 dropped write", 32'(tx_empty), 32'd1);
        check("R10 hold free", 32'(hold_full), 32'd0);

        // random formats and data
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d = 8'($urandom);
            logic [6:0] c = {1'b0, 6'($urandom)};
            send(d, c);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule